// File: doc/BRIEF.md
# Two-Player Reaction Game Controller

This block runs a reaction-time contest between two players. A start press begins a round. After a delay the players cannot predict, the start light comes on, and whichever player presses a stop button first gets a win light. If both presses land in the same clock cycle, both win lights come on. The round result stays displayed until start is pressed again, which begins a fresh round.

The delay has two sources working together. An 8-bit linear feedback shift register runs freely on every clock and is never stopped. When a round begins, its value at that moment is copied into an up-counter. The start light appears once that counter reaches its terminal count. All inputs are assumed to be clean, debounced and synchronous to `clk`. Reset is synchronous and active high.

Top module: `reaction_game`

## Requirements
- R1: While `rst` is sampled high, the round is abandoned. After that edge `start_light`, `win_a` and `win_b` are all low, the controller is idle, and the shift register holds 1.
- R2: The shift register moves its bits one place toward the MSB on every clock after reset. The new bit 0 is the XOR of bits 7, 6, 5 and 0. It never holds 0, so the values seen after reset are 1, 3, 7, 15, 31, 63, 126, 252, and so on.
- R3: Start sampled high while idle or showing a result copies the shift register's current value V into the delay counter and begins counting. `start_light` goes high exactly 256 − V clock edges after that start edge.
- R4: The delay counter steps up by one on each clock while it is nonzero, wraps from 255 to 0, and then holds at 0. A load takes priority over counting. Its terminal flag is high at 255.
- R5: `start_light` is high only in the waiting state. It stays high, with both win lights low, until a stop press is sampled.
- R6: In the waiting state, `stop_a` sampled high with `stop_b` low gives `win_a` high and `win_b` low from the next edge. A later `stop_b` press does not change this.
- R7: In the waiting state, `stop_b` sampled high with `stop_a` low gives `win_b` high and `win_a` low from the next edge.
- R8: Both stop buttons sampled high in the same waiting cycle turn on both win lights from the next edge, and `start_light` goes low.
- R9: Stop presses made while idle or counting are ignored. They do not end the count early, shift its length, or light a win lamp.
- R10: Start presses made while counting or waiting are ignored. The light still rises at the time set by the original load.
- R11: A result is held unchanged, and stop presses have no effect, until start is pressed. Start then reloads the counter from the live shift register value and begins a new round.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every register updates on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_btn | input | 1 | Start button, begins or restarts a round |
| stop_a | input | 1 | Player A stop button |
| stop_b | input | 1 | Player B stop button |
| start_light | output | 1 | High while players should react |
| win_a | output | 1 | Player A win lamp |
| win_b | output | 1 | Player B win lamp |

## Verification
Some checks are made on every cycle. The shift register must move one step toward the MSB and never reach zero. The delay counter must step, wrap and hold, and must take a load in preference to counting. Loads may happen only from the idle or result states. The start light must never be lit together with a win lamp. A waiting-state press pattern must lead to the matching result on the next edge, and a result must stay stable until start. The scenarios cover what those per-cycle properties cannot show. The light's rise is timed exactly against the value the free-running register held at the moment start was pressed. Reset and early presses are shown to leave that timing unchanged. Whole rounds are shown to end with A first, B first or a tie, including a restart from a finished round.

// File: rtl/rg_pkg.sv
package rg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_COUNT = 3'd1,
    ST_WAIT  = 3'd2,
    ST_AWIN  = 3'd3,
    ST_BWIN  = 3'd4,
    ST_TIE   = 3'd5
  } game_state_e;
endpackage

// File: rtl/rg_lfsr.sv
module rg_lfsr #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] TAPS = 8'hE1,
  parameter logic [W-1:0] SEED = 1
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] value
);
  logic feedback;

  // parity of the tapped bits becomes the new LSB
  always_comb feedback = ^(value & TAPS);

  always_ff @(posedge clk) begin
    if (rst) value <= SEED;
    else     value <= {value[W-2:0], feedback};
  end

  assert_lfsr_nonzero_R2: assert property (@(posedge clk) disable iff (rst)
    value != '0);

  assert_lfsr_shift_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> value[W-1:1] == $past(value[W-2:0]));
endmodule

// File: rtl/rg_delay_cnt.sv
module rg_delay_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic         tc
);
  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] count_q, count_d;

  always_comb begin
    count_d = count_q;
    if (load)                count_d = din;
    else if (count_q != '0)  count_d = count_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) count_q <= '0;
    else     count_q <= count_d;
  end

  always_comb tc = (count_q == TOP);

  assert_cnt_load_R4: assert property (@(posedge clk) disable iff (rst)
    load |=> count_q == $past(din));

  assert_cnt_step_R4: assert property (@(posedge clk) disable iff (rst)
    (!load && count_q != '0) |=> count_q == W'($past(count_q) + 1'b1));

  assert_cnt_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!load && count_q == '0) |=> count_q == '0);
endmodule

// File: rtl/rg_arbiter.sv
module rg_arbiter
  import rg_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start_btn,
  input  logic stop_a,
  input  logic stop_b,
  input  logic tc,
  output logic load,
  output logic start_light,
  output logic win_a,
  output logic win_b
);
  game_state_e state_q, state_d;
  logic finished;

  always_comb finished = (state_q == ST_AWIN) || (state_q == ST_BWIN) ||
                         (state_q == ST_TIE);

  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_AWIN, ST_BWIN, ST_TIE: begin
        if (start_btn) begin
          load    = 1'b1;
          state_d = ST_COUNT;
        end
      end
      ST_COUNT: if (tc) state_d = ST_WAIT;
      ST_WAIT: begin
        if (stop_a && stop_b) state_d = ST_TIE;
        else if (stop_a)      state_d = ST_AWIN;
        else if (stop_b)      state_d = ST_BWIN;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  always_comb begin
    start_light = (state_q == ST_WAIT);
    win_a       = (state_q == ST_AWIN) || (state_q == ST_TIE);
    win_b       = (state_q == ST_BWIN) || (state_q == ST_TIE);
  end

  assert_load_origin_R3: assert property (@(posedge clk) disable iff (rst)
    load |-> (state_q == ST_IDLE || finished));

  assert_light_excl_R5: assert property (@(posedge clk) disable iff (rst)
    !(start_light && (win_a || win_b)));

  assert_a_first_R6: assert property (@(posedge clk) disable iff (rst)
    (start_light && stop_a && !stop_b) |=> (win_a && !win_b));

  assert_b_first_R7: assert property (@(posedge clk) disable iff (rst)
    (start_light && stop_b && !stop_a) |=> (win_b && !win_a));

  assert_tie_R8: assert property (@(posedge clk) disable iff (rst)
    (start_light && stop_a && stop_b) |=> (win_a && win_b && !start_light));

  assert_result_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (finished && !start_btn) |=> $stable(state_q));
endmodule

// File: rtl/reaction_game.sv
module reaction_game #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] TAPS = 8'hE1,
  parameter logic [W-1:0] SEED = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic start_btn,
  input  logic stop_a,
  input  logic stop_b,
  output logic start_light,
  output logic win_a,
  output logic win_b
);
  logic [W-1:0] rnd;
  logic         load;
  logic         tc;

  rg_lfsr #(.W(W), .TAPS(TAPS), .SEED(SEED)) u_lfsr (
    .clk(clk), .rst(rst), .value(rnd)
  );

  rg_delay_cnt #(.W(W)) u_cnt (
    .clk(clk), .rst(rst), .load(load), .din(rnd), .tc(tc)
  );

  rg_arbiter u_fsm (
    .clk(clk), .rst(rst), .start_btn(start_btn), .stop_a(stop_a),
    .stop_b(stop_b), .tc(tc), .load(load), .start_light(start_light),
    .win_a(win_a), .win_b(win_b)
  );
endmodule

// File: tb/reaction_game_tb.sv
`timescale 1ns/1ps
module reaction_game_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_btn = 1'b0, stop_a = 1'b0, stop_b = 1'b0;
  logic start_light, win_a, win_b;
  int   n_tests = 0, n_fail = 0;
  logic [7:0] m_lfsr;

  always #4 clk = ~clk;

  reaction_game u_dut (
    .clk(clk), .rst(rst), .start_btn(start_btn), .stop_a(stop_a),
    .stop_b(stop_b), .start_light(start_light), .win_a(win_a), .win_b(win_b)
  );

  // reference register built from the R2 rule
  always @(posedge clk) begin
    if (rst) m_lfsr <= 8'd1;
    else     m_lfsr <= {m_lfsr[6:0], m_lfsr[7] ^ m_lfsr[6] ^ m_lfsr[5] ^ m_lfsr[0]};
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int lamps();
    return {29'd0, start_light, win_a, win_b};
  endfunction

  // press start for one edge; returns the delay predicted from the live value
  task automatic launch(output int d);
    start_btn = 1'b1;
    d = 256 - int'(m_lfsr);
    tick(1);
    start_btn = 1'b0;
  endtask

  task automatic expect_light(input string req, input int d);
    if (d > 1) tick(d - 1);
    check(lamps() == 0, req, lamps(), 0);
    tick(1);
    check(lamps() == 4, req, lamps(), 4);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    tick(2);
    check(lamps() == 0, "R1 reset lamps", lamps(), 0);
    rst = 1'b0;
  endtask

  task automatic t_known_sequence();
    int d;
    tick(7);                       // register now at 252
    launch(d);
    check(d == 4, "R2 model value", d, 4);
    expect_light("R3 delay after 252", 4);
    stop_a = 1'b1; tick(1); stop_a = 1'b0;
    check(lamps() == 2, "R6 A first", lamps(), 2);
    stop_b = 1'b1; tick(1); stop_b = 1'b0;
    check(lamps() == 2, "R6 late B ignored", lamps(), 2);
  endtask

  task automatic t_restart_b();
    int d;
    tick(20);
    check(lamps() == 2, "R11 result held", lamps(), 2);
    stop_b = 1'b1; stop_a = 1'b1; tick(3); stop_b = 1'b0; stop_a = 1'b0;
    check(lamps() == 2, "R11 stops in result ignored", lamps(), 2);
    launch(d);
    check(lamps() == 0, "R11 restart clears lamps", lamps(), 0);
    expect_light("R3 restart delay", d);
    stop_b = 1'b1; tick(1); stop_b = 1'b0;
    check(lamps() == 1, "R7 B first", lamps(), 1);
  endtask

  task automatic t_ignored_presses();
    int d;
    launch(d);
    stop_a = 1'b1; stop_b = 1'b1; start_btn = 1'b1;
    if (d > 1) tick(d - 1);
    check(lamps() == 0, "R9 stops while counting", lamps(), 0);
    stop_a = 1'b0; stop_b = 1'b0;
    tick(1);
    check(lamps() == 4, "R10 start while counting", lamps(), 4);
    tick(5);
    check(lamps() == 4, "R10 start while waiting", lamps(), 4);
    start_btn = 1'b0;
    stop_a = 1'b1; stop_b = 1'b1; tick(1); stop_a = 1'b0; stop_b = 1'b0;
    check(lamps() == 3, "R8 tie", lamps(), 3);
  endtask

  task automatic t_reset_mid_and_long();
    int d;
    launch(d);
    tick(2);
    rst = 1'b1; tick(1);
    check(lamps() == 0, "R1 reset mid round", lamps(), 0);
    rst = 1'b0;
    launch(d);                     // register holds 1 right after reset
    check(d == 255, "R2 first value after reset", d, 255);
    expect_light("R4 full 255 count", 255);
    tick(30);
    check(lamps() == 4, "R5 light held", lamps(), 4);
    stop_a = 1'b1; tick(1); stop_a = 1'b0;
    check(lamps() == 2, "R6 A wins long round", lamps(), 2);
  endtask

  task automatic t_idle_stops();
    rst = 1'b1; tick(1); rst = 1'b0;
    stop_a = 1'b1; stop_b = 1'b1; tick(40); stop_a = 1'b0; stop_b = 1'b0;
    check(lamps() == 0, "R9 stops while idle", lamps(), 0);
  endtask

  initial begin
    tick(1);
    t_reset();
    t_known_sequence();
    t_restart_b();
    t_ignored_presses();
    t_reset_mid_and_long();
    t_idle_stops();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(8 * 20000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule